// File: doc/BRIEF.md
# Glitch-Free Gated Clock Output

This block drives a clock pin for use outside the chip. It takes a source clock, seen as a level sampled in a faster system clock domain, and a 2-bit disable field. When the field is zero the output follows the source. When the field is nonzero the output parks at logic high. The block never shortens a phase: a disable that arrives while the output is low waits for that low phase to end, and a later re-enable waits for a new falling edge of the source, so the first low phase after it is full length.

Clearing the disable field before the output has gone high cancels the pending disable, and the output keeps following the source. The source level passes through a configurable number of synchronizer stages. The output register adds one more cycle of delay.

Top module: `cko_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `clk_out` is 1. Reset leaves the block enabled, so with `dis_ctl` = 0 the output then follows the source.
- R2: When enabled (`dis_ctl` = 2'b00), a change of `src_tgl` appears on `clk_out` exactly SYNC_STAGES+1 system clock edges later.
- R3: Each nonzero value of `dis_ctl` (2'b01, 2'b10, 2'b11) disables the output. Once parked, the output stays at 1 whatever `src_tgl` does.
- R4: If `clk_out` is 1 at the edge where a nonzero `dis_ctl` is first seen, the output is frozen at 1 from then on. A later falling source edge does not reach it.
- R5: If `clk_out` is 0 when the disable is requested, it stays 0 until the synchronized source goes high. It then goes to 1 and stays there.
- R6: If `dis_ctl` returns to zero while the output is still low in a pending disable, the output keeps following the source. It parks neither then nor at the next rising edge.
- R7: After re-enable from the parked state, `clk_out` stays 1 until the synchronized source next falls from 1 to 0. From that edge on it follows the source.
- R8: A nonzero `dis_ctl` during the wait of R7 returns the block to parked. A source fall that happens while parked does not count as the resuming edge.
- R9: Every change of `clk_out` takes it to the synchronized source level of the previous cycle. No extra or shortened phases occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the source clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tgl | input | 1 | Source clock level, sampled by `clk` |
| dis_ctl | input | 2 | Disable field; any nonzero value disables the output |
| clk_out | output | 1 | Gated clock output, parked high when disabled |

## Verification
A steady toggle of the source with the field at zero shows the plain follow path and its fixed latency. Disables are issued in both output phases, which separates the immediate freeze from the wait for the low phase to end. A re-enable during a pending disable is set against a re-enable from the parked state: the first must keep toggling, and the second must hold high until a fresh falling edge. Source falls that happen while parked, followed by a re-enable with the source already low, show that an old edge is not taken as the resuming one.

// File: rtl/cko_gate_pkg.sv
package cko_gate_pkg;

    localparam int unsigned CTL_W = 2;

    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_DRAIN = 2'd1,
        GS_PARK  = 2'd2,
        GS_REARM = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic lvl;
        logic fell;
    } src_view_t;

    typedef struct packed {
        gate_state_e st;
        logic        out;
    } gate_reg_t;

    function automatic logic ctl_disables(input logic [CTL_W-1:0] c);
        return |c;
    endfunction

endpackage

// File: rtl/cko_src_sync.sv
module cko_src_sync
    import cko_gate_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      src_raw,
    output src_view_t view
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              lvl_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b1;
                else     chain[0] <= src_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b1;
        else     lvl_d <= chain[LAST];
    end

    always_comb begin
        view.lvl  = chain[LAST];
        view.fell = lvl_d & ~chain[LAST];
    end

endmodule

// File: rtl/cko_gate_fsm.sv
module cko_gate_fsm
    import cko_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  src_view_t   view,
    input  logic        dis_req,
    output logic        out,
    output gate_state_e state
);

    gate_reg_t cur;
    gate_reg_t nxt;

    always_comb begin
        nxt = cur;
        unique case (cur.st)
            GS_RUN: begin
                if (!dis_req) begin
                    nxt.out = view.lvl;
                end else if (cur.out) begin
                    nxt.st  = GS_PARK;
                    nxt.out = 1'b1;
                end else begin
                    nxt.out = view.lvl;
                    nxt.st  = view.lvl ? GS_PARK : GS_DRAIN;
                end
            end
            GS_DRAIN: begin
                nxt.out = view.lvl;
                if (!dis_req)      nxt.st = GS_RUN;
                else if (view.lvl) nxt.st = GS_PARK;
            end
            GS_PARK: begin
                nxt.out = 1'b1;
                if (!dis_req) nxt.st = GS_REARM;
            end
            GS_REARM: begin
                nxt.out = 1'b1;
                if (dis_req) begin
                    nxt.st = GS_PARK;
                end else if (view.fell) begin
                    nxt.st  = GS_RUN;
                    nxt.out = view.lvl;
                end
            end
            default: begin
                nxt.st  = GS_PARK;
                nxt.out = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st  <= GS_RUN;
            cur.out <= 1'b1;
        end else begin
            cur <= nxt;
        end
    end

    assign out   = cur.out;
    assign state = cur.st;

endmodule

// File: rtl/cko_gate.sv
module cko_gate
    import cko_gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_tgl,
    input  logic [CTL_W-1:0] dis_ctl,
    output logic             clk_out
);

    src_view_t   src_v;
    gate_state_e g_state;
    logic        dis_req;

    assign dis_req = ctl_disables(dis_ctl);

    cko_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .src_raw (src_tgl),
        .view    (src_v)
    );

    cko_gate_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .view    (src_v),
        .dis_req (dis_req),
        .out     (clk_out),
        .state   (g_state)
    );

endmodule

// File: rtl/cko_gate_chk.sv
module cko_gate_chk
    import cko_gate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CTL_W-1:0] dis_ctl,
    input logic             clk_out,
    input logic             src_lvl
);

    logic rst_d = 1'b0;

    always_ff @(posedge clk) rst_d <= rst;

    // R1: output is high in the cycle right after reset
    always @(negedge clk) begin
        if (rst_d) assert_reset_high_R1: assert (clk_out === 1'b1);
    end

    // R3, R4: a high output with disable requested stays high
    assert_park_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (dis_ctl != '0 && clk_out) |=> clk_out);

    // R3, R5: the output never falls while a disable was requested
    assert_no_fall_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_out) |-> $past(dis_ctl) == '0);

    // R9: every change lands on the previous synchronized source level
    assert_change_follows_src_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_out != $past(clk_out)) |-> clk_out == $past(src_lvl));

    // R5: disable during a low phase does not drop into a rise-then-fall glitch
    assert_no_glitch_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_out) && dis_ctl != '0) |=> clk_out);

endmodule

bind cko_gate cko_gate_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dis_ctl (dis_ctl),
    .clk_out (clk_out),
    .src_lvl (src_v.lvl)
);

// File: tb/cko_gate_test.sv
module cko_gate_test;

    localparam int unsigned STAGES = 2;
    localparam int unsigned LAT    = STAGES + 1;
    localparam int unsigned HOLD   = 5;

    typedef struct packed {
        logic       src;
        logic [1:0] ctl;
        logic       exp;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 1'b1, 8'd2},  // R2 follow high
        '{1'b0, 2'd0, 1'b0, 8'd2},  // R2 follow low
        '{1'b1, 2'd0, 1'b1, 8'd2},
        '{1'b0, 2'd0, 1'b0, 8'd2},
        '{1'b0, 2'd1, 1'b0, 8'd5},  // R5 low phase not cut
        '{1'b1, 2'd1, 1'b1, 8'd5},  // R5 goes high then parks
        '{1'b0, 2'd1, 1'b1, 8'd3},  // R3 parked with code 01
        '{1'b1, 2'd1, 1'b1, 8'd3},
        '{1'b0, 2'd2, 1'b1, 8'd3},  // R3 parked with code 10
        '{1'b1, 2'd2, 1'b1, 8'd7},
        '{1'b1, 2'd0, 1'b1, 8'd7},  // R7 waiting for a fall
        '{1'b0, 2'd0, 1'b0, 8'd7},  // R7 resumed on fall
        '{1'b1, 2'd0, 1'b1, 8'd2},
        '{1'b0, 2'd0, 1'b0, 8'd2},
        '{1'b0, 2'd2, 1'b0, 8'd6},  // R6 pending disable
        '{1'b0, 2'd0, 1'b0, 8'd6},  // R6 cancelled
        '{1'b1, 2'd0, 1'b1, 8'd6},
        '{1'b0, 2'd0, 1'b0, 8'd6},  // R6 still toggling
        '{1'b1, 2'd0, 1'b1, 8'd2},
        '{1'b1, 2'd3, 1'b1, 8'd4},  // R4 frozen with code 11
        '{1'b0, 2'd3, 1'b1, 8'd4},
        '{1'b1, 2'd3, 1'b1, 8'd4},
        '{1'b0, 2'd3, 1'b1, 8'd4},
        '{1'b0, 2'd0, 1'b1, 8'd7},  // R7 source already low: no resume
        '{1'b1, 2'd0, 1'b1, 8'd7},
        '{1'b1, 2'd1, 1'b1, 8'd8},  // R8 back to parked
        '{1'b0, 2'd1, 1'b1, 8'd8},  // R8 fall while parked
        '{1'b0, 2'd0, 1'b1, 8'd8},  // R8 old fall ignored
        '{1'b1, 2'd0, 1'b1, 8'd8},
        '{1'b0, 2'd0, 1'b0, 8'd7}   // R7 fresh fall resumes
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_tgl = 1'b1;
    logic [1:0] dis_ctl = 2'd0;
    logic       clk_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    cko_gate #(.SYNC_STAGES(STAGES)) uut (
        .clk     (clk),
        .rst     (rst),
        .src_tgl (src_tgl),
        .dis_ctl (dis_ctl),
        .clk_out (clk_out)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: clk_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        src_tgl = 1'b0;
        tick(4);
        check("R1 reset high", clk_out, 1'b1);
        rst = 1'b0;
        tick(1);
        check("R1 first cycle after reset", clk_out, 1'b1);
        tick(LAT);
        check("R1 enabled after reset follows source", clk_out, 1'b0);

        for (int i = 0; i < NV; i++) begin
            src_tgl = VEC[i].src;
            dis_ctl = VEC[i].ctl;
            tick(HOLD);
            checks++;
            if (clk_out !== VEC[i].exp) begin
                errors++;
                $display("FAIL R%0d vector %0d: clk_out=%b expected %b",
                         VEC[i].tag, i, clk_out, VEC[i].exp);
            end
        end

        // R2: exact latency of the follow path
        dis_ctl = 2'd0;
        src_tgl = 1'b1;
        tick(HOLD);
        src_tgl = 1'b0;
        tick(LAT - 1);
        check("R2 before latency", clk_out, 1'b1);
        tick(1);
        check("R2 at latency", clk_out, 1'b0);

        // R4: disable and source fall in the same cycle while high
        src_tgl = 1'b1;
        tick(HOLD);
        dis_ctl = 2'd1;
        src_tgl = 1'b0;
        tick(1);
        check("R4 frozen at once", clk_out, 1'b1);
        tick(HOLD);
        check("R4 fall not passed", clk_out, 1'b1);

        // R9: count output transitions while the source toggles
        dis_ctl = 2'd0;
        src_tgl = 1'b1;
        tick(HOLD);
        src_tgl = 1'b0;
        tick(HOLD);
        begin
            int   edges = 0;
            logic prev  = clk_out;
            for (int k = 0; k < 8; k++) begin
                src_tgl = ~src_tgl;
                for (int c = 0; c < 6; c++) begin
                    tick(1);
                    if (clk_out !== prev) edges++;
                    prev = clk_out;
                end
            end
            checks++;
            if (edges != 8) begin
                errors++;
                $display("FAIL R9 transitions: got %0d expected 8", edges);
            end
        end

        finish_run();
    end

endmodule